// File: doc/BRIEF.md
# SDRAM Read Burst Engine

This block models, on the device side, the read data path of a single-data-rate synchronous DRAM. Each rising clock edge it decodes the command pins. When it sees a READ it latches the bank, the starting column and the auto-precharge choice. After the configured CAS latency it streams one data word per clock on `dq_out`, and `dq_oe` is high while a word is valid.

Column addresses come from a sequencer that feeds a short shift pipeline. The pipeline is as deep as the largest latency. A READ that arrives during a burst takes over the sequencer. Words already in the pipeline still drain, so the new burst's data follows the old data without an idle cycle. The data array is modelled as a fixed computed pattern of bank and column, which lets a controller check every word it receives.

Burst length and latency are static configuration inputs. A per-bank flag records a pending auto-precharge. A one-cycle pulse reports the bank closed once the burst's final word has gone out.

Top module: `sdr_read_engine`

## Requirements
- R1: A READ is accepted only on a rising edge where `cke`=1, `cs_n`=0, `ras_n`=1, `cas_n`=0 and `we_n`=1. Any other pin combination, or `cke`=0, starts nothing, and `dq_oe` stays low.
- R2: With `cfg_cl3`=0 the first word is on `dq_out` with `dq_oe` high in the clock cycle that ends at the 2nd rising edge after the READ edge. With `cfg_cl3`=1 this is the cycle that ends at the 3rd edge.
- R3: The word for bank b and column c is `{b[1:0], 6'b101010, c[7:0]}`. The column is `addr[7:0]`, and the bank is `ba`.
- R4: `cfg_bl` selects the burst: 0 gives 1 word, 1 gives 2, 2 gives 4, 3 gives 8, and any other value gives a full page. Burst words appear on consecutive cycles.
- R5: A fixed burst wraps inside the aligned block of its length. For example, with length 4 a start at column 6 gives 6,7,4,5, and with length 8 a start at 0x33 gives 0x33..0x37,0x30..0x32.
- R6: A full-page burst never stops by itself. After column 255 it continues at column 0.
- R7: A READ issued during a burst truncates it. Old words for columns issued on edges before the new READ edge are still delivered. The new burst's first word follows in the very next cycle, with `dq_oe` staying high.
- R8: When the final word of a burst has gone out and no READ follows, `dq_oe` is low in the next cycle. `dq_out` reads 0 whenever `dq_oe` is low.
- R9: A READ with `addr[10]`=1 sets `ap_pend[bank]` on its edge. In the cycle after the burst's final word, `ap_done` pulses for one cycle with `ap_bank` set to that bank, and `ap_pend` for that bank clears on the following edge. A READ with `addr[10]`=0 sets no flag and produces no pulse.
- R10: While `rst_n` is low, `dq_oe`, `ap_done` and `ap_pend` are 0 and `dq_out` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable; commands are ignored while low |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| addr | input | 12 | Address; bits 7:0 are the column and bit 10 is the auto-precharge select |
| cfg_cl3 | input | 1 | 0 selects CAS latency 2, 1 selects latency 3 |
| cfg_bl | input | 3 | Burst length code |
| dq_out | output | 16 | Read data word |
| dq_oe | output | 1 | Data output enable |
| ap_done | output | 1 | One-cycle pulse: a bank was closed by auto-precharge |
| ap_bank | output | 2 | Bank reported by `ap_done` |
| ap_pend | output | 4 | Per-bank pending auto-precharge flags |

## Verification
Every data word carries its own bank and column. A corrupted sequencer index or captured start column therefore shows up as a wrong word at the output exactly CAS-latency cycles after the bad issue. A dropped or stuck pipeline valid bit shows as a gap in `dq_oe`, or an output enable that stays high, in the first cycle after the affected word. A lost truncation mark or last flag shifts or suppresses the `ap_done` pulse by one burst, which is visible one cycle after the final word.

// File: rtl/sdr_rd_pkg.sv
package sdr_rd_pkg;

  // Output pipeline depth bounds; the latency select picks one of them.
  localparam int unsigned LAT_MIN = 2;
  localparam int unsigned LAT_MAX = 3;
  localparam int unsigned BL_W    = 3;

  typedef enum logic [BL_W-1:0] {
    BL_ONE   = 3'd0,
    BL_TWO   = 3'd1,
    BL_FOUR  = 3'd2,
    BL_EIGHT = 3'd3,
    BL_PAGE  = 3'd7
  } burst_code_e;

  // Any code above the fixed lengths selects a full-page burst.
  function automatic logic is_page(input logic [BL_W-1:0] code);
    return code > BL_EIGHT;
  endfunction

endpackage

// File: rtl/sdr_rd_cmd_decode.sv
module sdr_rd_cmd_decode #(
  parameter int unsigned BANK_W = 2,
  parameter int unsigned COL_W  = 8,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned AP_BIT = 10
) (
  input  logic              cke,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic [BANK_W-1:0] ba,
  input  logic [ADDR_W-1:0] addr,
  output logic              rd_go,
  output logic [BANK_W-1:0] rd_bank,
  output logic [COL_W-1:0]  rd_col,
  output logic              rd_ap
);

  // Command truth table restricted to the column-read entry.
  always_comb begin
    rd_go   = cke & ~cs_n & ras_n & ~cas_n & we_n;
    rd_bank = ba;
    rd_col  = addr[COL_W-1:0];
    rd_ap   = addr[AP_BIT];
  end

endmodule

// File: rtl/sdr_rd_col_seq.sv
module sdr_rd_col_seq
  import sdr_rd_pkg::*;
#(
  parameter int unsigned BANK_W = 2,
  parameter int unsigned COL_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BL_W-1:0]   cfg_bl,
  input  logic              rd_go,
  input  logic [BANK_W-1:0] rd_bank,
  input  logic [COL_W-1:0]  rd_col,
  input  logic              rd_ap,
  output logic              iss_valid,
  output logic              iss_last,
  output logic              iss_ap,
  output logic [BANK_W-1:0] iss_bank,
  output logic [COL_W-1:0]  iss_col
);

  logic              act_q, act_d;
  logic              ap_q, ap_d;
  logic [BANK_W-1:0] bank_q, bank_d;
  logic [COL_W-1:0]  start_q, start_d;
  logic [COL_W-1:0]  idx_q, idx_d;
  logic              page;
  logic [COL_W-1:0]  wrap_mask;
  logic [COL_W-1:0]  seq_col;
  logic              seq_last;
  logic              seq_en;

  // Wrap mask: all ones for a page, length-1 for a fixed burst.
  always_comb begin
    page      = is_page(cfg_bl);
    wrap_mask = page ? {COL_W{1'b1}}
                     : COL_W'((32'd1 << cfg_bl[1:0]) - 32'd1);
    seq_col   = (start_q & ~wrap_mask) | ((start_q + idx_q) & wrap_mask);
    seq_last  = ~page & (idx_q == wrap_mask);
  end

  // Next state and issue slot; a new READ always wins over the running burst.
  always_comb begin
    act_d     = act_q;
    ap_d      = ap_q;
    bank_d    = bank_q;
    start_d   = start_q;
    idx_d     = idx_q;
    iss_valid = 1'b0;
    iss_last  = 1'b0;
    iss_ap    = ap_q;
    iss_bank  = bank_q;
    iss_col   = seq_col;
    if (rd_go) begin
      iss_valid = 1'b1;
      iss_last  = ~page & (wrap_mask == '0);
      iss_ap    = rd_ap;
      iss_bank  = rd_bank;
      iss_col   = rd_col;
      act_d     = ~iss_last;
      ap_d      = rd_ap;
      bank_d    = rd_bank;
      start_d   = rd_col;
      idx_d     = COL_W'(1);
    end else if (act_q) begin
      iss_valid = 1'b1;
      iss_last  = seq_last;
      act_d     = ~seq_last;
      idx_d     = idx_q + COL_W'(1);
    end
  end

  assign seq_en = rd_go | act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
    end else if (seq_en) begin
      act_q <= act_d;
    end
  end

  always_ff @(posedge clk) begin
    if (seq_en) begin
      ap_q    <= ap_d;
      bank_q  <= bank_d;
      start_q <= start_d;
      idx_q   <= idx_d;
    end
  end

  AST_PAGE_NEVER_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && page && !rd_go) |=> act_q);  // R6

  AST_PAGE_WRAPS_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && page && iss_col == {COL_W{1'b1}}) |=> (rd_go || iss_col == '0));  // R6

endmodule

// File: rtl/sdr_rd_out_pipe.sv
module sdr_rd_out_pipe
  import sdr_rd_pkg::*;
#(
  parameter int unsigned BANK_W = 2,
  parameter int unsigned COL_W  = 8,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_cl3,
  input  logic              trunc,
  input  logic              iss_valid,
  input  logic              iss_last,
  input  logic              iss_ap,
  input  logic [BANK_W-1:0] iss_bank,
  input  logic [COL_W-1:0]  iss_col,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              fin_ap,
  output logic [BANK_W-1:0] fin_bank
);

  localparam int unsigned FILL_W = DATA_W - BANK_W - COL_W;

  // Computed contents stand in for the cell array.
  function automatic logic [DATA_W-1:0] word_of(input logic [BANK_W-1:0] b,
                                                input logic [COL_W-1:0]  c);
    logic [FILL_W-1:0] fill;
    for (int i = 0; i < int'(FILL_W); i++) fill[i] = 1'(i % 2);
    return {b, fill, c};
  endfunction

  genvar g;
  for (g = 1; g <= int'(LAT_MAX); g++) begin : g_stage
    logic              v_q, l_q, a_q;
    logic [BANK_W-1:0] b_q;
    logic [COL_W-1:0]  c_q;
    logic              v_d, l_d, a_d;
    logic [BANK_W-1:0] b_d;
    logic [COL_W-1:0]  c_d;

    if (g == 1) begin : g_head
      always_comb begin
        v_d = iss_valid;
        l_d = iss_last;
        a_d = iss_ap;
        b_d = iss_bank;
        c_d = iss_col;
      end
    end else begin : g_body
      // The second stage holds the newest old word when a READ truncates.
      localparam bit MARK = (g == 2);
      always_comb begin
        v_d = g_stage[g-1].v_q;
        l_d = g_stage[g-1].l_q | (MARK & trunc);
        a_d = g_stage[g-1].a_q;
        b_d = g_stage[g-1].b_q;
        c_d = g_stage[g-1].c_q;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        l_q <= 1'b0;
        a_q <= 1'b0;
      end else begin
        v_q <= v_d;
        if (v_d) begin
          l_q <= l_d;
          a_q <= a_d;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (v_d) begin
        b_q <= b_d;
        c_q <= c_d;
      end
    end
  end

  logic              out_v, out_l, out_a;
  logic [BANK_W-1:0] out_b;
  logic [COL_W-1:0]  out_c;

  always_comb begin
    if (cfg_cl3) begin
      out_v = g_stage[LAT_MAX].v_q;
      out_l = g_stage[LAT_MAX].l_q;
      out_a = g_stage[LAT_MAX].a_q;
      out_b = g_stage[LAT_MAX].b_q;
      out_c = g_stage[LAT_MAX].c_q;
    end else begin
      out_v = g_stage[LAT_MIN].v_q;
      out_l = g_stage[LAT_MIN].l_q;
      out_a = g_stage[LAT_MIN].a_q;
      out_b = g_stage[LAT_MIN].b_q;
      out_c = g_stage[LAT_MIN].c_q;
    end
    dq_oe    = out_v;
    dq_out   = out_v ? word_of(out_b, out_c) : '0;
    fin_ap   = out_v & out_l & out_a;
    fin_bank = out_b;
  end

  AST_CL2_FIRST_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_cl3 && iss_valid) |-> ##2 dq_oe);  // R2

  AST_CL3_FIRST_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_cl3 && iss_valid) |-> ##3 dq_oe);  // R2

  AST_NO_GAP_MID_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && !out_l) |=> dq_oe);  // R7

endmodule

// File: rtl/sdr_rd_ap_track.sv
module sdr_rd_ap_track #(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned BANK_W    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_go,
  input  logic [BANK_W-1:0]    rd_bank,
  input  logic                 rd_ap,
  input  logic                 fin_ap,
  input  logic [BANK_W-1:0]    fin_bank,
  output logic                 ap_done,
  output logic [BANK_W-1:0]    ap_bank,
  output logic [NUM_BANKS-1:0] ap_pend
);

  logic [NUM_BANKS-1:0] pend_d;
  logic                 set_hit;

  // Set has priority so a fresh READ to a closing bank stays recorded.
  always_comb begin
    for (int b = 0; b < int'(NUM_BANKS); b++) begin
      pend_d[b] = ap_pend[b];
      if (ap_done && ap_bank == BANK_W'(b)) pend_d[b] = 1'b0;
      if (rd_go && rd_ap && rd_bank == BANK_W'(b)) pend_d[b] = 1'b1;
    end
    set_hit = rd_go & rd_ap & (rd_bank == ap_bank);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ap_done <= 1'b0;
      ap_pend <= '0;
    end else begin
      ap_done <= fin_ap;
      ap_pend <= pend_d;
    end
  end

  always_ff @(posedge clk) begin
    if (fin_ap) ap_bank <= fin_bank;
  end

  AST_PEND_CLEARS_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (ap_done && !set_hit) |=> !ap_pend[$past(ap_bank)]);  // R9

endmodule

// File: rtl/sdr_read_engine.sv
module sdr_read_engine
  import sdr_rd_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 4,
  parameter int unsigned COL_W     = 8,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned AP_BIT    = 10,
  localparam int unsigned BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cke,
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic [BANK_W-1:0]    ba,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 cfg_cl3,
  input  logic [BL_W-1:0]      cfg_bl,
  output logic [DATA_W-1:0]    dq_out,
  output logic                 dq_oe,
  output logic                 ap_done,
  output logic [BANK_W-1:0]    ap_bank,
  output logic [NUM_BANKS-1:0] ap_pend
);

  logic              rd_go, rd_ap;
  logic [BANK_W-1:0] rd_bank;
  logic [COL_W-1:0]  rd_col;
  logic              iss_valid, iss_last, iss_ap;
  logic [BANK_W-1:0] iss_bank;
  logic [COL_W-1:0]  iss_col;
  logic              fin_ap;
  logic [BANK_W-1:0] fin_bank;

  sdr_rd_cmd_decode #(
    .BANK_W(BANK_W), .COL_W(COL_W), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT)
  ) u_dec (
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr),
    .rd_go(rd_go), .rd_bank(rd_bank), .rd_col(rd_col), .rd_ap(rd_ap)
  );

  sdr_rd_col_seq #(.BANK_W(BANK_W), .COL_W(COL_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .cfg_bl(cfg_bl),
    .rd_go(rd_go), .rd_bank(rd_bank), .rd_col(rd_col), .rd_ap(rd_ap),
    .iss_valid(iss_valid), .iss_last(iss_last), .iss_ap(iss_ap),
    .iss_bank(iss_bank), .iss_col(iss_col)
  );

  sdr_rd_out_pipe #(.BANK_W(BANK_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_pipe (
    .clk(clk), .rst_n(rst_n), .cfg_cl3(cfg_cl3), .trunc(rd_go),
    .iss_valid(iss_valid), .iss_last(iss_last), .iss_ap(iss_ap),
    .iss_bank(iss_bank), .iss_col(iss_col),
    .dq_out(dq_out), .dq_oe(dq_oe), .fin_ap(fin_ap), .fin_bank(fin_bank)
  );

  sdr_rd_ap_track #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_ap (
    .clk(clk), .rst_n(rst_n),
    .rd_go(rd_go), .rd_bank(rd_bank), .rd_ap(rd_ap),
    .fin_ap(fin_ap), .fin_bank(fin_bank),
    .ap_done(ap_done), .ap_bank(ap_bank), .ap_pend(ap_pend)
  );

  AST_DONE_FOLLOWS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    ap_done |-> $past(dq_oe));  // R9

  AST_IGNORED_CMD_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke || cs_n || !ras_n || cas_n || !we_n) |-> !iss_valid || !u_dec.rd_go);  // R1

endmodule

// File: tb/sdr_read_engine_test.sv
`timescale 1ns/1ps
module sdr_read_engine_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cke, cs_n, ras_n, cas_n, we_n;
  logic [1:0]  ba;
  logic [11:0] addr;
  logic        cfg_cl3;
  logic [2:0]  cfg_bl;
  logic [15:0] dq_out;
  logic        dq_oe;
  logic        ap_done;
  logic [1:0]  ap_bank;
  logic [3:0]  ap_pend;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  sdr_read_engine uut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
    .cfg_cl3(cfg_cl3), .cfg_bl(cfg_bl),
    .dq_out(dq_out), .dq_oe(dq_oe), .ap_done(ap_done),
    .ap_bank(ap_bank), .ap_pend(ap_pend)
  );

  function automatic logic [15:0] exp_word(input logic [1:0] b, input logic [7:0] c);
    return {b, 6'b101010, c};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic rd, input logic [1:0] b, input logic [7:0] c,
                       input logic a10);
    cke  = 1'b1;
    cs_n = 1'b0;
    ras_n = 1'b1;
    cas_n = rd ? 1'b0 : 1'b1;
    we_n = 1'b1;
    ba   = b;
    addr = {1'b0, a10, 2'b00, c};
  endtask

  typedef struct packed {
    logic       cl3;
    logic [2:0] bl;
    logic       rd;
    logic [1:0] bank;
    logic [7:0] col;
    logic       a10;
    logic       oe;
    logic [1:0] ebank;
    logic [7:0] ecol;
    logic       apd;
    logic [1:0] apb;
  } vec_t;

  // Each row: outputs expected after the previous edge, then the command for the next edge.
  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 3'd2, 1'b1, 2'd1, 8'h06, 1'b1, 1'b0, 2'd0, 8'h00, 1'b0, 2'd0},
    '{1'b0, 3'd2, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 2'd0, 8'h00, 1'b0, 2'd0},
    '{1'b0, 3'd2, 1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 2'd1, 8'h06, 1'b0, 2'd0},
    '{1'b0, 3'd2, 1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 2'd1, 8'h07, 1'b0, 2'd0},
    '{1'b0, 3'd2, 1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 2'd1, 8'h04, 1'b0, 2'd0},
    '{1'b0, 3'd2, 1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 2'd1, 8'h05, 1'b0, 2'd0},
    '{1'b0, 3'd2, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 2'd0, 8'h00, 1'b1, 2'd1},
    '{1'b0, 3'd2, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 2'd0, 8'h00, 1'b0, 2'd0},
    '{1'b1, 3'd3, 1'b1, 2'd2, 8'h10, 1'b0, 1'b0, 2'd0, 8'h00, 1'b0, 2'd0},
    '{1'b1, 3'd3, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 2'd0, 8'h00, 1'b0, 2'd0},
    '{1'b1, 3'd3, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 2'd0, 8'h00, 1'b0, 2'd0},
    '{1'b1, 3'd3, 1'b1, 2'd3, 8'h33, 1'b1, 1'b1, 2'd2, 8'h10, 1'b0, 2'd0},
    '{1'b1, 3'd3, 1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 2'd2, 8'h11, 1'b0, 2'd0},
    '{1'b1, 3'd3, 1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 2'd2, 8'h12, 1'b0, 2'd0},
    '{1'b1, 3'd3, 1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 2'd3, 8'h33, 1'b0, 2'd0},
    '{1'b1, 3'd3, 1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 2'd3, 8'h34, 1'b0, 2'd0},
    '{1'b1, 3'd3, 1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 2'd3, 8'h35, 1'b0, 2'd0},
    '{1'b1, 3'd3, 1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 2'd3, 8'h36, 1'b0, 2'd0},
    '{1'b1, 3'd3, 1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 2'd3, 8'h37, 1'b0, 2'd0},
    '{1'b1, 3'd3, 1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 2'd3, 8'h30, 1'b0, 2'd0},
    '{1'b1, 3'd3, 1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 2'd3, 8'h31, 1'b0, 2'd0},
    '{1'b1, 3'd3, 1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 2'd3, 8'h32, 1'b0, 2'd0},
    '{1'b1, 3'd3, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 2'd0, 8'h00, 1'b1, 2'd3},
    '{1'b1, 3'd3, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 2'd0, 8'h00, 1'b0, 2'd0}
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : stim
    rst_n   = 1'b0;
    cfg_cl3 = 1'b0;
    cfg_bl  = 3'd2;
    drive(1'b0, 2'd0, 8'h00, 1'b0);
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 oe", 32'(dq_oe), 32'd0);
    chk("R10 dq", 32'(dq_out), 32'd0);
    chk("R10 ap_done", 32'(ap_done), 32'd0);
    chk("R10 ap_pend", 32'(ap_pend), 32'd0);
    rst_n = 1'b1;

    // Vector table: BL4 with auto-precharge, then CL3 BL8 truncation.
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      chk("R4 R8 oe", 32'(dq_oe), 32'(VEC[i].oe));
      if (VEC[i].oe)
        chk("R2 R3 R5 R7 data", 32'(dq_out), 32'(exp_word(VEC[i].ebank, VEC[i].ecol)));
      chk("R9 ap_done", 32'(ap_done), 32'(VEC[i].apd));
      if (VEC[i].apd) chk("R9 ap_bank", 32'(ap_bank), 32'(VEC[i].apb));
      cfg_cl3 = VEC[i].cl3;
      cfg_bl  = VEC[i].bl;
      drive(VEC[i].rd, VEC[i].bank, VEC[i].col, VEC[i].a10);
    end

    // R1: near-miss commands start nothing.
    cfg_cl3 = 1'b0;
    cfg_bl  = 3'd2;
    @(negedge clk);
    drive(1'b1, 2'd1, 8'h20, 1'b0);
    cke = 1'b0;
    @(negedge clk);
    drive(1'b1, 2'd1, 8'h20, 1'b0);
    we_n = 1'b0;
    @(negedge clk);
    drive(1'b1, 2'd1, 8'h20, 1'b0);
    cs_n = 1'b1;
    @(negedge clk);
    drive(1'b0, 2'd0, 8'h00, 1'b0);
    for (int k = 0; k < 5; k++) begin
      chk("R1 ignored command oe", 32'(dq_oe), 32'd0);
      @(negedge clk);
    end

    // R4 R9: single-word burst at CL3 with auto-precharge on bank 2.
    cfg_cl3 = 1'b1;
    cfg_bl  = 3'd0;
    drive(1'b1, 2'd2, 8'h05, 1'b1);
    @(negedge clk);
    drive(1'b0, 2'd0, 8'h00, 1'b0);
    chk("R9 pend set", 32'(ap_pend), 32'h4);
    @(negedge clk);
    chk("R2 not yet", 32'(dq_oe), 32'd0);
    @(negedge clk);
    chk("R4 single oe", 32'(dq_oe), 32'd1);
    chk("R3 single data", 32'(dq_out), 32'(exp_word(2'd2, 8'h05)));
    @(negedge clk);
    chk("R8 oe drops", 32'(dq_oe), 32'd0);
    chk("R8 dq zero", 32'(dq_out), 32'd0);
    chk("R9 done pulse", 32'(ap_done), 32'd1);
    chk("R9 done bank", 32'(ap_bank), 32'd2);
    @(negedge clk);
    chk("R9 done once", 32'(ap_done), 32'd0);
    chk("R9 pend cleared", 32'(ap_pend), 32'h0);

    // R6: full page from column 254 at CL2, no precharge.
    cfg_cl3 = 1'b0;
    cfg_bl  = 3'd7;
    drive(1'b1, 2'd0, 8'hFE, 1'b0);
    @(negedge clk);
    drive(1'b0, 2'd0, 8'h00, 1'b0);
    chk("R9 no pend without A10", 32'(ap_pend), 32'h0);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      chk("R6 page oe", 32'(dq_oe), 32'd1);
      chk("R6 page data", 32'(dq_out), 32'(exp_word(2'd0, 8'(254 + i))));
      chk("R9 page no done", 32'(ap_done), 32'd0);
    end
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10 reset ends page", 32'(dq_oe), 32'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule